// File: doc/BRIEF.md
# Prioritized Memory Port Replicator

This block lets three independent clients share one pipelined, read-only memory port. Each client offers read addresses on a valid/ready channel. The block picks at most one of them per cycle and forwards that address to the memory. The memory returns the word a fixed number of cycles later, and the block routes it back to the client that asked. A small FIFO records the owning port of every access in flight. Each port has its own response buffer, and the consumer drains that buffer through its own valid/ready channel.

A request is admitted only when its port has room for the result. That room counts words still inside the memory as well as words stored but not yet read. Returned data therefore always has a slot. A consumer that stops reading holds back only its own port. When requests are waiting, the higher-numbered port wins, and the memory is issued an address in every cycle in which some port both requests and has room.

Top module: `mem_port_share`

## Requirements
- R1: Port p (p = 0, 1, 2) transfers a request in a cycle when `req_valid[p]` and `req_ready[p]` are both high. At most one port transfers per cycle.
- R2: `mem_req_valid` is high exactly in the cycles with a request transfer. In those cycles `mem_req_addr` equals the winning port's address field `req_addr[p*AW +: AW]`.
- R3: Among ports that request and have room, port 2 wins over port 1, and port 1 wins over port 0. A port's `req_ready` is low while a higher-numbered port is both requesting and has room.
- R4: In any cycle where at least one port requests and has room, the memory is issued an address.
- R5: A word the memory returns LAT cycles after an issue is delivered only to the port that issued it. That port's `rsp_valid` can first be high LAT+1 cycles after the issue cycle.
- R6: Each port holds at most LAT+2 requests, counting those in flight and those stored unread. While a port is at that limit, its `req_ready` is low.
- R7: While `rsp_valid[p]` is high and `rsp_ready[p]` is low, the next cycle keeps `rsp_valid[p]` high and its data field `rsp_data[p*DW +: DW]` unchanged.
- R8: A synchronous active-high `rst` empties the owner FIFO and all response buffers and restores full credit. After reset `rsp_valid` is 0, and `req_ready` is 3'b111 while no port requests.
- R9: On each port, response words come out in the same order as that port's accepted requests.
- R10: A port whose consumer stalls until its credit runs out does not block the other ports. Their requests are granted in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 3 | Request valid, one bit per port |
| req_addr | input | 3*AW | Read addresses; port p in bits p*AW +: AW |
| req_ready | output | 3 | Request ready, one bit per port |
| rsp_valid | output | 3 | Response valid, one bit per port |
| rsp_data | output | 3*DW | Response words; port p in bits p*DW +: DW |
| rsp_ready | input | 3 | Response accept, one bit per port |
| mem_req_valid | output | 1 | Address issued to memory this cycle |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory data valid, LAT cycles after issue |
| mem_rsp_data | input | DW | Memory read data |

## Verification
The checks that run every cycle cover the following:
- the single-grant rule and its tie to the memory issue strobe;
- full use of the memory whenever a port requests and has credit;
- never writing into a full response buffer;
- never seeing returned data without an outstanding owner entry;
- holding a response that has not been taken;
- empty outputs after reset.

The bench's reference model and its scenarios are needed for the rest:
- the exact priority order;
- correct steering of each word to its port;
- per-port ordering;
- the first cycle in which a response can appear;
- credit exhaustion on a stalled port, and the freedom of the other ports while it lasts.

// File: rtl/mem_port_share.sv
module mem_port_share #(
  parameter int AW  = 21,
  parameter int DW  = 32,
  parameter int LAT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      req_valid,
  input  logic [3*AW-1:0] req_addr,
  output logic [2:0]      req_ready,
  output logic [2:0]      rsp_valid,
  output logic [3*DW-1:0] rsp_data,
  input  logic [2:0]      rsp_ready,
  output logic            mem_req_valid,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data
);
  localparam int NP  = 3;
  localparam int TD  = (LAT < 2) ? 2 : LAT;
  localparam int TPW = $clog2(TD);
  localparam int TCW = $clog2(TD + 1);
  localparam int RD  = LAT + 2;
  localparam int BPW = $clog2(RD);
  localparam int BCW = $clog2(RD + 1);

  logic [NP-1:0]  cred, elig, grant, buf_wr, buf_full, rsp_pop;
  logic [1:0]     win;
  logic [1:0]     tag_mem [TD];
  logic [TPW-1:0] tag_wr, tag_rd;
  logic [TCW-1:0] tag_cnt;
  logic [1:0]     tag_head;
  logic           rsp_hit;

  assign elig          = req_valid & cred;
  assign grant         = elig[2] ? 3'b100 : elig[1] ? 3'b010 : {2'b00, elig[0]};
  assign win           = elig[2] ? 2'd2 : elig[1] ? 2'd1 : 2'd0;
  assign req_ready     = {cred[2], cred[1] & ~elig[2], cred[0] & ~elig[2] & ~elig[1]};
  assign mem_req_valid = |elig;
  assign rsp_pop       = rsp_valid & rsp_ready;
  assign tag_head      = tag_mem[tag_rd];
  assign rsp_hit       = mem_rsp_valid && (tag_cnt != '0);

  always_comb begin
    mem_req_addr = req_addr[0 +: AW];
    if (win == 2'd1) mem_req_addr = req_addr[AW +: AW];
    if (win == 2'd2) mem_req_addr = req_addr[2*AW +: AW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_wr  <= '0;
      tag_rd  <= '0;
      tag_cnt <= '0;
    end else begin
      if (mem_req_valid)
        tag_wr <= (tag_wr == TPW'(TD - 1)) ? '0 : tag_wr + 1'b1;
      if (rsp_hit)
        tag_rd <= (tag_rd == TPW'(TD - 1)) ? '0 : tag_rd + 1'b1;
      tag_cnt <= tag_cnt + TCW'(mem_req_valid) - TCW'(rsp_hit);
    end
  end

  always_ff @(posedge clk)
    if (mem_req_valid) tag_mem[tag_wr] <= win;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [BCW-1:0] occ, cnt;
    logic [BPW-1:0] wp, rp;
    logic [DW-1:0]  store [RD];

    assign cred[p]     = occ < BCW'(RD);
    assign buf_wr[p]   = rsp_hit && (tag_head == 2'(p));
    assign buf_full[p] = cnt == BCW'(RD);
    assign rsp_valid[p] = cnt != '0;
    assign rsp_data[p*DW +: DW] = store[rp];

    always_ff @(posedge clk) begin
      if (rst) begin
        occ <= '0;
        cnt <= '0;
        wp  <= '0;
        rp  <= '0;
      end else begin
        occ <= occ + BCW'(grant[p]) - BCW'(rsp_pop[p]);
        cnt <= cnt + BCW'(buf_wr[p]) - BCW'(rsp_pop[p]);
        if (buf_wr[p])
          wp <= (wp == BPW'(RD - 1)) ? '0 : wp + 1'b1;
        if (rsp_pop[p])
          rp <= (rp == BPW'(RD - 1)) ? '0 : rp + 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (buf_wr[p]) store[wp] <= mem_rsp_data;
  end
endmodule

// File: rtl/mem_port_share_chk.sv
module mem_port_share_chk #(
  parameter int DW  = 32,
  parameter int TCW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      req_valid,
  input logic [2:0]      req_ready,
  input logic [2:0]      rsp_valid,
  input logic [2:0]      rsp_ready,
  input logic [3*DW-1:0] rsp_data,
  input logic            mem_req_valid,
  input logic            mem_rsp_valid,
  input logic [2:0]      cred,
  input logic [2:0]      buf_wr,
  input logic [2:0]      buf_full,
  input logic [TCW-1:0]  tag_cnt
);
  a_r1_one_transfer: assert property (@(posedge clk) disable iff (rst)
    $countones(req_valid & req_ready) <= 1);

  a_r2_issue_tracks_handshake: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid == (|(req_valid & req_ready)));

  a_r4_full_use: assert property (@(posedge clk) disable iff (rst)
    (|(req_valid & cred)) |-> mem_req_valid);

  a_r5_owner_known: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> (tag_cnt != '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (buf_wr & buf_full) == 3'b000);

  for (genvar p = 0; p < 3; p++) begin : g_hold
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid[p] && !rsp_ready[p]) |=>
        (rsp_valid[p] && $stable(rsp_data[p*DW +: DW])));
  end

  a_r8_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rsp_valid == 3'b000));
endmodule

bind mem_port_share mem_port_share_chk #(.DW(DW), .TCW(TCW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .cred(cred), .buf_wr(buf_wr), .buf_full(buf_full), .tag_cnt(tag_cnt)
);

// File: tb/mem_port_share_bench.sv
`timescale 1ns/1ps
module mem_port_share_bench;
  localparam int AW = 21, DW = 32, LAT = 8, RD = LAT + 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      req_valid = '0;
  logic [3*AW-1:0] req_addr = '0;
  logic [2:0]      req_ready;
  logic [2:0]      rsp_valid;
  logic [3*DW-1:0] rsp_data;
  logic [2:0]      rsp_ready = '0;
  logic            mem_req_valid;
  logic [AW-1:0]   mem_req_addr;
  logic            mem_rsp_valid;
  logic [DW-1:0]   mem_rsp_data;

  always #2 clk = ~clk;

  mem_port_share #(.AW(AW), .DW(DW), .LAT(LAT)) u_mem_port_share (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  function automatic logic [DW-1:0] fmem(input logic [AW-1:0] a);
    return {a[10:0], a} ^ 32'hC3A5_0F1E;
  endfunction

  logic          pv [LAT];
  logic [AW-1:0] pa [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= mem_req_valid;
      pa[0] <= mem_req_addr;
      for (int k = 1; k < LAT; k++) begin
        pv[k] <= pv[k-1];
        pa[k] <= pa[k-1];
      end
    end
  end
  assign mem_rsp_valid = pv[LAT-1];
  assign mem_rsp_data  = pv[LAT-1] ? fmem(pa[LAT-1]) : 32'hDEAD_BEEF;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] qd [3][$];
  int            qt [3][$];
  logic [2:0]    held;
  logic [DW-1:0] held_data [3];
  int nvec = 0, nbad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; req_valid = '0; rsp_ready = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    for (int p = 0; p < 3; p++) begin qd[p].delete(); qt[p].delete(); end
    held = '0;
    @(negedge clk);
    chk(rsp_valid == 3'b000, "R8", "rsp_valid after reset", 96'(rsp_valid), 96'(0));
    chk(req_ready == 3'b111, "R8", "req_ready after reset", 96'(req_ready), 96'(7));
    chk(mem_req_valid == 1'b0, "R8", "mem_req_valid idle", 96'(mem_req_valid), 96'(0));
  endtask

  task automatic step(input logic [2:0] v, input logic [2:0] r);
    logic [2:0] elig, xr, xv;
    int w;
    @(posedge clk); #1;
    req_valid = v; rsp_ready = r;
    for (int p = 0; p < 3; p++) req_addr[p*AW +: AW] = AW'($urandom);
    @(negedge clk);
    for (int p = 0; p < 3; p++) elig[p] = v[p] && (qd[p].size() < RD);
    xr = {(qd[2].size() < RD), (qd[1].size() < RD) && !elig[2],
          (qd[0].size() < RD) && !elig[2] && !elig[1]};
    w = elig[2] ? 2 : elig[1] ? 1 : elig[0] ? 0 : -1;
    chk(req_ready == xr, "R3", "req_ready", 96'(req_ready), 96'(xr));
    chk($countones(req_valid & req_ready) <= 1, "R1", "transfers", 96'(req_valid & req_ready), 96'(xr & v));
    chk(mem_req_valid == (w >= 0), "R4", "mem_req_valid", 96'(mem_req_valid), 96'(w >= 0));
    if (w >= 0)
      chk(mem_req_addr == req_addr[w*AW +: AW], "R2", "mem_req_addr",
          96'(mem_req_addr), 96'(req_addr[w*AW +: AW]));
    for (int p = 0; p < 3; p++) begin
      if (qd[p].size() == RD)
        chk(!req_ready[p], "R6", "ready at credit limit", 96'(req_ready[p]), 96'(0));
      xv[p] = (qd[p].size() > 0) && (qt[p][0] <= cyc);
      chk(rsp_valid[p] == xv[p], "R5", "rsp_valid", 96'(rsp_valid[p]), 96'(xv[p]));
      if (xv[p])
        chk(rsp_data[p*DW +: DW] == qd[p][0], "R9", "rsp_data order",
            96'(rsp_data[p*DW +: DW]), 96'(qd[p][0]));
      if (held[p])
        chk(rsp_valid[p] && rsp_data[p*DW +: DW] == held_data[p], "R7", "held response",
            96'(rsp_data[p*DW +: DW]), 96'(held_data[p]));
    end
    // R10: a stalled full port 2 leaves port 1 free to win
    if (qd[2].size() == RD && v[1] && qd[1].size() < RD)
      chk(req_ready[1], "R10", "port1 ready while port2 stalled", 96'(req_ready[1]), 96'(1));
    for (int p = 0; p < 3; p++) begin
      held[p] = xv[p] && !r[p];
      held_data[p] = xv[p] ? qd[p][0] : '0;
      if (xv[p] && r[p]) begin void'(qd[p].pop_front()); void'(qt[p].pop_front()); end
    end
    if (w >= 0) begin
      qd[w].push_back(fmem(req_addr[w*AW +: AW]));
      qt[w].push_back(cyc + LAT + 1);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    held = '0;
    do_reset();
    repeat (30)  step(3'b111, 3'b111);
    repeat (40)  step(3'b111, 3'b011);
    repeat (20)  step(3'b000, 3'b111);
    repeat (300) step(3'($urandom), 3'($urandom) | 3'($urandom));
    repeat (12)  step(3'b111, 3'b000);
    do_reset();
    repeat (50)  step(3'b001, 3'b001);
    repeat (40)  step(3'b110, 3'b010);
    repeat (200) step(3'($urandom), 3'($urandom));
    repeat (30)  step(3'b000, 3'b111);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule